// File: doc/BRIEF.md
# Network controller control register file

This block holds the software-visible control and status state of a network controller: sixty-four 16-bit registers on a word-wide register bus. Writes go through per-register rules. Some registers are gated by the software-reset state. Some keep only certain bits, some store the complement of the value written, and the interrupt status register is write-one-to-clear. Read data is combinational from the addressed register.

A write to the command register is turned into single-cycle action pulses for the transmit, receive, timer, ring-read and address-table-load engines. Each engine reports completion on its own done line, and that clears the matching command bit. Engines raise status bits through set-request inputs. The interrupt output is high while any unmasked status bit is set.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After hardware reset, reads return: command (addr 0x00) = 0x0094, interrupt mask (0x01) = 0, interrupt status (0x02) = 0, end-of-buffer count (0x0F) = 0x02F8. `irq` is 0 and `act_pulse` is 0.
- R2: `irq` is 1 exactly when (mask AND status) is nonzero, and follows either register one cycle after it changes. Writes to the mask keep only bits 14:0, so status bit 15 can never raise `irq`.
- R3: Writing the status register clears only those bits that are 1 in the written value. `stat_set` ORs bits into the status register every cycle. A bit that is both set and cleared in the same cycle ends up set.
- R4: A status write that clears a set buffer-exhausted bit (status bit 5) produces a one-cycle pulse on `act_pulse[8]` in the cycle after the write. A write of that bit while it is already clear produces no pulse.
- R5: Configuration register A (0x03, write mask 0xBFFF) and configuration register B (0x04, write mask 0xF017) accept writes only while command bit 7 (reset) is set. Writes at other times leave them unchanged.
- R6: Transmit control (0x05) keeps only bits 15:12 of a write and receive control (0x06) keeps only bits 15:5. The four ring pointers (0x08 to 0x0B) store the written value with bit 0 forced to 0.
- R7: The three error tally registers (0x0C to 0x0E) store the bitwise complement of the written value.
- R8: A command write made while reset is set, whose value has bit 7 clear, clears only bit 7. It leaves every other command bit unchanged and produces no action pulse.
- R9: Any other command write ORs (value AND 0x03BF) into the command register. In the following cycle, `act_pulse[n]` is 1 for one cycle for each written command bit n in that mask. Bit 6 and bits 15:10 are ignored. Command bit meanings: 0 halt, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 reset, 8 ring read, 9 table load.
- R10: The receiver-on command clears bit 2. The receiver-off command written without receiver-on clears bit 3. The timer-start command clears bit 4. The timer-stop command written without timer-start clears bit 5.
- R11: The reset command clears bits 9, 8, 1 and 0 and sets bits 7 and 2, overriding the other bits written with it.
- R12: `act_done[n]` clears command bit n. If a command write sets the same bit in the same cycle, the bit ends up set.
- R13: The revision register (0x10) always reads the `REV_ID` parameter (default 0x0004). The table readback ports 0x11, 0x12 and 0x13 return `cam_word[15:0]`, `[31:16]` and `[47:32]` while reset is set, and 0 otherwise. Writes to all four are ignored.
- R14: Every other address is plain 16-bit storage that reads back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| cam_word | input | 48 | Address-table entry currently selected for readback |
| stat_set | input | 16 | Per-bit status set requests from the engines |
| act_done | input | 10 | Per-command completion from the engines |
| act_pulse | output | 10 | One-cycle action pulses, indexed by command bit |
| irq | output | 1 | Interrupt request |

## Verification
A wrong command register shows on the very next read of address 0x00. It also shows on `act_pulse` in the cycle after the offending write: either a pulse appears that should not, or a pulse is missing. A lost or stuck reset bit appears as configuration writes that stick or fail, and as table ports that read zero or data at the wrong time. A corrupted mask or status bit appears on `irq` one cycle after the write or set request that exposes it. A missed buffer-exhausted clear is seen as an absent ring-read pulse one cycle after the status write.

// File: rtl/nic_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared constants and write-rule functions of the NIC control register file.
// Assumes a 6-bit word address and 16-bit registers.
package nic_ctrl_pkg;
    localparam int REG_DW = 16;
    localparam int REG_AW = 6;
    localparam int CMD_N  = 10;

    localparam logic [REG_AW-1:0] A_CMD   = 6'h00;
    localparam logic [REG_AW-1:0] A_MASK  = 6'h01;
    localparam logic [REG_AW-1:0] A_STAT  = 6'h02;
    localparam logic [REG_AW-1:0] A_CFGA  = 6'h03;
    localparam logic [REG_AW-1:0] A_CFGB  = 6'h04;
    localparam logic [REG_AW-1:0] A_TXC   = 6'h05;
    localparam logic [REG_AW-1:0] A_RXC   = 6'h06;
    localparam logic [REG_AW-1:0] A_PTR0  = 6'h08;
    localparam logic [REG_AW-1:0] A_TALY0 = 6'h0C;
    localparam logic [REG_AW-1:0] A_EOB   = 6'h0F;
    localparam logic [REG_AW-1:0] A_REV   = 6'h10;
    localparam logic [REG_AW-1:0] A_CAM0  = 6'h11;
    localparam logic [REG_AW-1:0] A_CAM1  = 6'h12;
    localparam logic [REG_AW-1:0] A_CAM2  = 6'h13;

    localparam logic [REG_DW-1:0] CMD_MASK   = 16'h03BF;
    localparam logic [REG_DW-1:0] CMD_HW_RST = 16'h0094;
    localparam logic [REG_DW-1:0] CFGA_MASK  = 16'hBFFF;
    localparam logic [REG_DW-1:0] CFGB_MASK  = 16'hF017;
    localparam logic [REG_DW-1:0] TXC_MASK   = 16'hF000;
    localparam logic [REG_DW-1:0] RXC_MASK   = 16'hFFE0;
    localparam logic [REG_DW-1:0] IMSK_MASK  = 16'h7FFF;
    localparam logic [REG_DW-1:0] EOB_RESET  = 16'h02F8;

    localparam int B_HALT   = 0;
    localparam int B_TX     = 1;
    localparam int B_RXOFF  = 2;
    localparam int B_RXON   = 3;
    localparam int B_TSTOP  = 4;
    localparam int B_TSTART = 5;
    localparam int B_SRST   = 7;
    localparam int B_RING   = 8;
    localparam int B_CAM    = 9;
    localparam int B_RBE    = 5;

    // True for the four ring pointer addresses.
    function automatic logic is_ptr(input logic [REG_AW-1:0] a);
        return (a >= A_PTR0) && (a <= A_PTR0 + 6'd3);
    endfunction

    // True for the three tally counter addresses.
    function automatic logic is_tally(input logic [REG_AW-1:0] a);
        return (a >= A_TALY0) && (a <= A_TALY0 + 6'd2);
    endfunction

    // Whether the generic store accepts a write at this address.
    function automatic logic store_writable(input logic [REG_AW-1:0] a, input logic in_rst);
        case (a)
            A_CMD, A_MASK, A_STAT, A_REV, A_CAM0, A_CAM1, A_CAM2: return 1'b0;
            A_CFGA, A_CFGB: return in_rst;
            default: return 1'b1;
        endcase
    endfunction

    // Value stored for a write, after the per-register rule.
    function automatic logic [REG_DW-1:0] store_shape(input logic [REG_AW-1:0] a,
                                                      input logic [REG_DW-1:0] d);
        if (is_ptr(a))   return d & 16'hFFFE;
        if (is_tally(a)) return ~d;
        case (a)
            A_CFGA:  return d & CFGA_MASK;
            A_CFGB:  return d & CFGB_MASK;
            A_TXC:   return d & TXC_MASK;
            A_RXC:   return d & RXC_MASK;
            default: return d;
        endcase
    endfunction

    // Hardware reset value of a generic store entry.
    function automatic logic [REG_DW-1:0] store_reset(input logic [REG_AW-1:0] a);
        return (a == A_EOB) ? EOB_RESET : '0;
    endfunction
endpackage

// File: rtl/nic_ctrl_store.sv
`timescale 1ns/1ps
// Generic register storage: one entry per address, with write rules from the
// package. Assumes the command, mask and status addresses live elsewhere and
// are never written here.
module nic_ctrl_store
    import nic_ctrl_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          in_reset,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] cells [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_ent
        localparam logic [AW-1:0] MY = AW'(gi);
        logic [DW-1:0] q;
        // Entry register: reset value, then gated and shaped writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= store_reset(MY);
            else if (wr && (addr == MY) && store_writable(MY, in_reset))
                q <= store_shape(MY, wdata);
        end
        assign cells[gi] = q;
    end

    // Read port.
    assign rdata = cells[addr];

    p_cfg_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_CFGA) && !in_reset) |=> $stable(cells[A_CFGA]));

    p_tally_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_TALY0)) |=> (cells[A_TALY0] == ~$past(wdata)));

    p_ptr_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cells[A_PTR0][0] | cells[A_PTR0 + 6'd1][0] |
          cells[A_PTR0 + 6'd2][0] | cells[A_PTR0 + 6'd3][0]));
endmodule

// File: rtl/nic_ctrl_cmd.sv
`timescale 1ns/1ps
// Command register: reset-exit rule, set-only command bits with pairwise
// side effects, soft reset, engine completion clears, and one-cycle pulses.
// Assumes ring_req is a one-cycle request from the interrupt unit.
module nic_ctrl_cmd
    import nic_ctrl_pkg::*;
#(
    parameter int DW = REG_DW,
    parameter int NC = CMD_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wdata,
    input  logic [NC-1:0] done,
    input  logic          ring_req,
    output logic [DW-1:0] cmd_q,
    output logic          in_reset,
    output logic [NC-1:0] pulse
);
    logic          accept;
    logic [DW-1:0] cmd_bits;
    logic [DW-1:0] cmd_d;

    assign in_reset = cmd_q[B_SRST];
    assign cmd_bits = wdata & CMD_MASK;

    // Next command value: completion clears first, then the write.
    always_comb begin
        accept = wr_cmd && !(cmd_q[B_SRST] && !wdata[B_SRST]);
        cmd_d  = cmd_q & ~DW'(done);
        if (wr_cmd && !accept) begin
            cmd_d[B_SRST] = 1'b0;
        end else if (accept) begin
            cmd_d = cmd_d | cmd_bits;
            if (cmd_bits[B_RXON])        cmd_d[B_RXOFF]  = 1'b0;
            else if (cmd_bits[B_RXOFF])  cmd_d[B_RXON]   = 1'b0;
            if (cmd_bits[B_TSTART])      cmd_d[B_TSTOP]  = 1'b0;
            else if (cmd_bits[B_TSTOP])  cmd_d[B_TSTART] = 1'b0;
            if (cmd_bits[B_SRST]) begin
                cmd_d[B_CAM]   = 1'b0;
                cmd_d[B_RING]  = 1'b0;
                cmd_d[B_TX]    = 1'b0;
                cmd_d[B_HALT]  = 1'b0;
                cmd_d[B_SRST]  = 1'b1;
                cmd_d[B_RXOFF] = 1'b1;
            end
        end
    end

    // Command register and action pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_HW_RST;
            pulse <= '0;
        end else begin
            cmd_q <= cmd_d;
            pulse <= (accept ? cmd_bits[NC-1:0] : '0) | (NC'(ring_req) << B_RING);
        end
    end

    p_exit_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && cmd_q[B_SRST] && !wdata[B_SRST] && (done == '0))
        |=> (!cmd_q[B_SRST] && (pulse == '0) &&
             (cmd_q[NC-1:0] == ($past(cmd_q[NC-1:0]) & ~(NC'(1) << B_SRST)))));

    p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[B_SRST])
        |=> (cmd_q[B_SRST] && cmd_q[B_RXOFF] && !cmd_q[B_TX] && !cmd_q[B_HALT] &&
             !cmd_q[B_RING] && !cmd_q[B_CAM]));

    p_done_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((done != '0) && !wr_cmd) |=> ((cmd_q[NC-1:0] & $past(done)) == '0));
endmodule

// File: rtl/nic_ctrl_irq.sv
`timescale 1ns/1ps
// Interrupt mask and write-one-to-clear status with engine set requests.
// Flags a ring-read request when a write clears the buffer-exhausted bit.
module nic_ctrl_irq
    import nic_ctrl_pkg::*;
#(
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mask,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] stat_set,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] stat_q,
    output logic          irq,
    output logic          ring_req
);
    // Request a ring read when a set buffer-exhausted bit is written as 1.
    assign ring_req = wr_stat && wdata[B_RBE] && stat_q[B_RBE];

    // Interrupt level from the unmasked status bits.
    assign irq = |(mask_q & stat_q);

    // Mask and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata & IMSK_MASK;
            stat_q <= (stat_q & ~(wr_stat ? wdata : '0)) | stat_set;
        end
    end

    p_mask_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[DW-1]);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (stat_set == '0)) |=> ((stat_q & $past(wdata)) == '0));

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
endmodule

// File: rtl/nic_ctrl_regs.sv
`timescale 1ns/1ps
// NIC control register file top: decodes the bus, hosts the command,
// interrupt and storage units, and muxes read data including the revision
// and the reset-gated address-table readback ports.
module nic_ctrl_regs
    import nic_ctrl_pkg::*;
#(
    parameter int          AW     = REG_AW,
    parameter int          DW     = REG_DW,
    parameter int          NC     = CMD_N,
    parameter logic [15:0] REV_ID = 16'h0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [3*DW-1:0] cam_word,
    input  logic [DW-1:0]   stat_set,
    input  logic [NC-1:0]   act_done,
    output logic [NC-1:0]   act_pulse,
    output logic            irq
);
    logic [DW-1:0] cmd_q, mask_q, stat_q, store_rd;
    logic          in_reset, ring_req;
    logic          wr_cmd, wr_mask, wr_stat;

    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign wr_mask = bus_wr && (bus_addr == A_MASK);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);

    nic_ctrl_cmd #(.DW(DW), .NC(NC)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(bus_wdata),
        .done(act_done), .ring_req(ring_req), .cmd_q(cmd_q),
        .in_reset(in_reset), .pulse(act_pulse)
    );

    nic_ctrl_irq #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_stat(wr_stat),
        .wdata(bus_wdata), .stat_set(stat_set), .mask_q(mask_q),
        .stat_q(stat_q), .irq(irq), .ring_req(ring_req)
    );

    nic_ctrl_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .in_reset(in_reset), .rdata(store_rd)
    );

    // Read data mux.
    always_comb begin
        case (bus_addr)
            A_CMD:   bus_rdata = cmd_q;
            A_MASK:  bus_rdata = mask_q;
            A_STAT:  bus_rdata = stat_q;
            A_REV:   bus_rdata = REV_ID;
            A_CAM0:  bus_rdata = in_reset ? cam_word[DW-1:0]    : '0;
            A_CAM1:  bus_rdata = in_reset ? cam_word[2*DW-1:DW] : '0;
            A_CAM2:  bus_rdata = in_reset ? cam_word[3*DW-1:2*DW] : '0;
            default: bus_rdata = store_rd;
        endcase
    end

    p_cam_hidden_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset && (bus_addr == A_CAM0)) |-> (bus_rdata == '0));
endmodule

// File: tb/nic_ctrl_regs_test.sv
`timescale 1ns/1ps
// Directed bench for the NIC control register file.
module nic_ctrl_regs_test;
    localparam logic [5:0] R_CMD = 6'h00, R_MSK = 6'h01, R_STA = 6'h02,
                           R_CFA = 6'h03, R_CFB = 6'h04, R_TXC = 6'h05,
                           R_RXC = 6'h06, R_PT0 = 6'h08, R_PT3 = 6'h0B,
                           R_TL0 = 6'h0C, R_TL2 = 6'h0E, R_EOB = 6'h0F,
                           R_REV = 6'h10, R_CM0 = 6'h11, R_CM1 = 6'h12,
                           R_CM2 = 6'h13, R_GEN = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [47:0] cam_word = 48'h3333_2222_1111;
    logic [15:0] stat_set = '0;
    logic [9:0]  act_done = '0;
    logic [9:0]  act_pulse;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    nic_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cam_word(cam_word),
        .stat_set(stat_set), .act_done(act_done), .act_pulse(act_pulse),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_side(input logic [5:0] a, input logic [15:0] d,
                           input logic [9:0] dn, input logic [15:0] ss);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; act_done = dn; stat_set = ss;
        @(negedge clk);
        bus_wr = 1'b0; act_done = '0; stat_set = '0;
    endtask

    task automatic rdchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic pchk(input string tag, input logic [9:0] exp);
        chk(tag, {6'b0, act_pulse}, {6'b0, exp});
    endtask

    task automatic t_reset;
        rdchk("R1 cmd", R_CMD, 16'h0094);
        rdchk("R1 mask", R_MSK, 16'h0000);
        rdchk("R1 status", R_STA, 16'h0000);
        rdchk("R1 eob", R_EOB, 16'h02F8);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        pchk("R1 pulse", 10'h000);
    endtask

    task automatic t_reset_gated;
        rdchk("R13 cam0", R_CM0, 16'h1111);
        rdchk("R13 cam1", R_CM1, 16'h2222);
        rdchk("R13 cam2", R_CM2, 16'h3333);
        rdchk("R13 rev", R_REV, 16'h0004);
        wr(R_REV, 16'hFFFF);
        rdchk("R13 rev write ignored", R_REV, 16'h0004);
        wr(R_CM0, 16'hABCD);
        rdchk("R13 cam write ignored", R_CM0, 16'h1111);
        wr(R_CFA, 16'hFFFF);
        rdchk("R5 cfga in reset", R_CFA, 16'hBFFF);
        wr(R_CFB, 16'hFFFF);
        rdchk("R5 cfgb in reset", R_CFB, 16'hF017);
        wr(R_CMD, 16'h0000);
        pchk("R8 exit pulse", 10'h000);
        rdchk("R8 exit cmd", R_CMD, 16'h0014);
        wr(R_CFA, 16'h1234);
        rdchk("R5 cfga locked", R_CFA, 16'hBFFF);
        wr(R_CFB, 16'h0000);
        rdchk("R5 cfgb locked", R_CFB, 16'hF017);
        rdchk("R13 cam hidden", R_CM1, 16'h0000);
    endtask

    task automatic t_shapes;
        wr(R_TXC, 16'hFFFF);
        rdchk("R6 txc", R_TXC, 16'hF000);
        wr(R_RXC, 16'hFFFF);
        rdchk("R6 rxc", R_RXC, 16'hFFE0);
        wr(R_PT0, 16'h1235);
        rdchk("R6 ptr0", R_PT0, 16'h1234);
        wr(R_PT3, 16'hFFFF);
        rdchk("R6 ptr3", R_PT3, 16'hFFFE);
        wr(R_TL0, 16'h00FF);
        rdchk("R7 tally0", R_TL0, 16'hFF00);
        wr(R_TL2, 16'h0000);
        rdchk("R7 tally2", R_TL2, 16'hFFFF);
        wr(R_GEN, 16'hA5A5);
        rdchk("R14 plain", R_GEN, 16'hA5A5);
        wr(R_EOB, 16'h0123);
        rdchk("R14 eob plain", R_EOB, 16'h0123);
    endtask

    task automatic t_commands;
        wr(R_CMD, 16'h0002);
        pchk("R9 tx pulse", 10'h002);
        rdchk("R9 tx cmd", R_CMD, 16'h0016);
        pchk("R9 pulse one cycle", 10'h000);
        wr_side(R_GEN, 16'hA5A5, 10'h002, 16'h0);
        rdchk("R12 done clears", R_CMD, 16'h0014);
        wr_side(R_CMD, 16'h0002, 10'h002, 16'h0);
        rdchk("R12 write wins", R_CMD, 16'h0016);
        wr(R_CMD, 16'h0008);
        pchk("R9 rxon pulse", 10'h008);
        rdchk("R10 rxon", R_CMD, 16'h001A);
        wr(R_CMD, 16'h0020);
        rdchk("R10 tstart", R_CMD, 16'h002A);
        wr(R_CMD, 16'h0010);
        rdchk("R10 tstop", R_CMD, 16'h001A);
        wr(R_CMD, 16'h0004);
        rdchk("R10 rxoff", R_CMD, 16'h0016);
        wr(R_CMD, 16'h0040);
        pchk("R9 bit6 no pulse", 10'h000);
        wr(R_CMD, 16'hFC00);
        pchk("R9 high bits no pulse", 10'h000);
        rdchk("R9 ignored bits", R_CMD, 16'h0016);
    endtask

    task automatic t_interrupts;
        @(negedge clk); stat_set = 16'h0021;
        @(negedge clk); stat_set = 16'h0000;
        rdchk("R3 set request", R_STA, 16'h0021);
        chk("R2 masked irq", {15'b0, irq}, 16'h0);
        wr(R_MSK, 16'hFFFF);
        chk("R2 irq up", {15'b0, irq}, 16'h1);
        rdchk("R2 mask msb", R_MSK, 16'h7FFF);
        wr(R_STA, 16'h0001);
        pchk("R4 no pulse bit0", 10'h000);
        rdchk("R3 w1c partial", R_STA, 16'h0020);
        wr(R_STA, 16'h0020);
        pchk("R4 ring pulse", 10'h100);
        chk("R2 irq down", {15'b0, irq}, 16'h0);
        rdchk("R3 w1c empty", R_STA, 16'h0000);
        wr(R_STA, 16'h0020);
        pchk("R4 no pulse when clear", 10'h000);
        @(negedge clk); stat_set = 16'h8080;
        @(negedge clk); stat_set = 16'h0000;
        chk("R2 irq bit7", {15'b0, irq}, 16'h1);
        wr_side(R_STA, 16'h0080, 10'h000, 16'h0080);
        rdchk("R3 set wins", R_STA, 16'h8080);
        wr(R_STA, 16'h0080);
        chk("R2 msb cannot interrupt", {15'b0, irq}, 16'h0);
        rdchk("R3 bit15 kept", R_STA, 16'h8000);
    endtask

    task automatic t_soft_reset;
        wr(R_CMD, 16'h0300);
        pchk("R9 ring+load pulse", 10'h300);
        rdchk("R9 ring+load cmd", R_CMD, 16'h0316);
        wr(R_CMD, 16'h0080);
        pchk("R11 reset pulse", 10'h080);
        rdchk("R11 soft reset cmd", R_CMD, 16'h0094);
        wr(R_CFA, 16'h0001);
        rdchk("R5 cfga after soft reset", R_CFA, 16'h0001);
        wr(R_CMD, 16'h0002);
        pchk("R8 no tx pulse", 10'h000);
        rdchk("R8 only reset cleared", R_CMD, 16'h0014);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_reset_gated;
        t_shapes;
        t_commands;
        t_interrupts;
        t_soft_reset;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule